// File: doc/BRIEF.md
# Leading-Zero-Suppressing Seven-Segment Decoder Chain

This block turns a row of BCD digits into active-low seven-segment drive patterns for a multi-digit display. It blanks the zeros at the front of a number and leaves lit every zero that follows a non-zero digit. Each digit slice decodes its own 4-bit value. A blanking request passes from the most significant slice down to its neighbour on the right. A slice goes dark when it holds a zero and its left neighbour reports that it went dark for the same reason.

The chain also takes a lamp-test input that lights every segment, and one blank-input pin per digit that turns that digit off whatever else is applied. A pin on the most significant slice sets whether suppression may start at all. The `KEEP_LAST_ZERO` parameter decides whether the rightmost digit may go dark. The whole block is combinational.

Top module: `sevenseg_chain`

## Requirements
- R1: With every override inactive and no suppression, a digit value of 0 to 9 drives its standard pattern on `segN`. Bit 0 of each 7-bit digit field is segment a (top). The bits then run clockwise through b, c, d, e and f, and bit 6 is g (middle). A 0 bit means the segment is lit. Active-high, the patterns for 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F (hex).
- R2: A digit value of 10 to 15 lights only segment g (active-low field 3F hex) and never goes dark through suppression.
- R3: `lampTest_n` low drives every segment of a digit low (lit), unless that digit's blank input is low.
- R4: `blankIn_n[k]` low drives all seven segments of digit k high (dark), and it takes priority over lamp test.
- R5: A digit that holds zero and has its ripple input low goes fully dark, provided its blank input and lamp test are both inactive.
- R6: `rippleOut_n[k]` is low exactly when digit k holds zero and its ripple input is low. Lamp test and blank input do not affect it.
- R7: Digit k's ripple input is `rippleOut_n[k+1]`, and the most significant digit takes `leadBlank_n`. So only the run of zeros at the front of the number goes dark, and zeros after a non-zero digit stay lit.
- R8: With `KEEP_LAST_ZERO`=1, the ripple input of digit 0 is held inactive. An all-zero number then still shows one 0.
- R9: With `leadBlank_n` high, no digit is suppressed, so leading zeros are shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bcdIn | input | 4*DIGITS | BCD values; digit k is bits [4k+3:4k], digit DIGITS-1 is the leftmost |
| blankIn_n | input | DIGITS | Per-digit forced blank, active low |
| lampTest_n | input | 1 | Light all segments, active low |
| leadBlank_n | input | 1 | Ripple input of the leftmost digit, active low |
| segN | output | 7*DIGITS | Active-low segments; digit k is bits [7k+6:7k] |
| rippleOut_n | output | DIGITS | Per-digit ripple output, active low |

## Verification
The immediate assertions check the local rules at every evaluation. A forced blank is dark, lamp test lights everything, the ripple output is low only for a suppressed zero, and a zero whose left neighbour stays lit shows as a 0. Only the bench's sweeps show that whole numbers come out right. These include suppression stopping at the first non-zero digit, the rightmost zero surviving, and the pattern for every code from 0 to 15 in every position under every override.

// File: rtl/sevenseg_pkg.sv
`timescale 1ns/1ps
package sevenseg_pkg;

  localparam int SEG_W = 7;
  localparam int BCD_W = 4;

  // control-to-datapath strobes for one digit
  typedef struct packed {
    logic forceOff;   // all segments dark
    logic forceOn;    // all segments lit
    logic suppress;   // zero blanked by the ripple chain
  } segStrobe_t;

  // active-high pattern, bit0 = a ... bit6 = g
  function automatic logic [SEG_W-1:0] glyphOf(input logic [BCD_W-1:0] v);
    logic [SEG_W-1:0] p;
    case (v)
      4'd0:    p = 7'h3F;
      4'd1:    p = 7'h06;
      4'd2:    p = 7'h5B;
      4'd3:    p = 7'h4F;
      4'd4:    p = 7'h66;
      4'd5:    p = 7'h6D;
      4'd6:    p = 7'h7D;
      4'd7:    p = 7'h07;
      4'd8:    p = 7'h7F;
      4'd9:    p = 7'h6F;
      default: p = 7'h40;  // out-of-range code: middle bar only
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sevenseg_ctrl.sv
`timescale 1ns/1ps
module sevenseg_ctrl
  import sevenseg_pkg::*;
(
  input  logic             isZero,
  input  logic             lampTest_n,
  input  logic             blankIn_n,
  input  logic             rippleIn_n,
  output segStrobe_t       strobe,
  output logic             rippleOut_n
);

  logic zeroChained;

  always_comb begin
    zeroChained      = isZero && !rippleIn_n;
    strobe.forceOff  = !blankIn_n;
    strobe.forceOn   = blankIn_n && !lampTest_n;
    strobe.suppress  = blankIn_n && lampTest_n && zeroChained;
    rippleOut_n      = !zeroChained;
  end

  always_comb begin
    AST_STROBE_EXCLUSIVE: assert ($countones({strobe.forceOff, strobe.forceOn, strobe.suppress}) <= 1); // R4
  end

endmodule

// File: rtl/sevenseg_datapath.sv
`timescale 1ns/1ps
module sevenseg_datapath
  import sevenseg_pkg::*;
(
  input  logic [BCD_W-1:0] bcd,
  input  segStrobe_t       strobe,
  output logic             isZero,
  output logic [SEG_W-1:0] segN
);

  logic [SEG_W-1:0] litMask;

  always_comb begin
    isZero = (bcd == '0);
    if (strobe.forceOff || strobe.suppress) begin
      litMask = '0;
    end else if (strobe.forceOn) begin
      litMask = '1;
    end else begin
      litMask = glyphOf(bcd);
    end
    segN = ~litMask;
  end

endmodule

// File: rtl/sevenseg_digit.sv
`timescale 1ns/1ps
module sevenseg_digit
  import sevenseg_pkg::*;
(
  input  logic [BCD_W-1:0] bcd,
  input  logic             lampTest_n,
  input  logic             blankIn_n,
  input  logic             rippleIn_n,
  output logic [SEG_W-1:0] segN,
  output logic             rippleOut_n
);

  segStrobe_t strobe;
  logic       isZero;

  sevenseg_ctrl ctrl_i (
    .isZero      (isZero),
    .lampTest_n  (lampTest_n),
    .blankIn_n   (blankIn_n),
    .rippleIn_n  (rippleIn_n),
    .strobe      (strobe),
    .rippleOut_n (rippleOut_n)
  );

  sevenseg_datapath dp_i (
    .bcd    (bcd),
    .strobe (strobe),
    .isZero (isZero),
    .segN   (segN)
  );

  always_comb begin
    if (!blankIn_n)
      AST_BLANK_DARK: assert (segN == '1); // R4
    if (blankIn_n && !lampTest_n)
      AST_LAMP_ALL_LIT: assert (segN == '0); // R3
    if (!rippleOut_n)
      AST_RIPPLE_ONLY_ZERO: assert (bcd == '0 && !rippleIn_n); // R6
    if (!rippleOut_n && blankIn_n && lampTest_n)
      AST_SUPPRESSED_DARK: assert (segN == '1); // R5
    if (bcd > 4'd9 && blankIn_n && lampTest_n)
      AST_BAD_CODE_DASH: assert (segN == 7'h3F); // R2
  end

endmodule

// File: rtl/sevenseg_chain.sv
`timescale 1ns/1ps
module sevenseg_chain
  import sevenseg_pkg::*;
#(
  parameter int DIGITS         = 4,
  parameter bit KEEP_LAST_ZERO = 1'b1
) (
  input  logic [BCD_W*DIGITS-1:0] bcdIn,
  input  logic [DIGITS-1:0]       blankIn_n,
  input  logic                    lampTest_n,
  input  logic                    leadBlank_n,
  output logic [SEG_W*DIGITS-1:0] segN,
  output logic [DIGITS-1:0]       rippleOut_n
);

  localparam int MSD = DIGITS - 1;

  logic [DIGITS-1:0] rippleIn_n;

  for (genvar k = 0; k < DIGITS; k++) begin : g_digit
    if (k == 0 && KEEP_LAST_ZERO) begin : g_keep
      assign rippleIn_n[k] = 1'b1;
    end else if (k == MSD) begin : g_lead
      assign rippleIn_n[k] = leadBlank_n;
    end else begin : g_link
      assign rippleIn_n[k] = rippleOut_n[k+1];
    end

    sevenseg_digit digit_i (
      .bcd         (bcdIn[BCD_W*k +: BCD_W]),
      .lampTest_n  (lampTest_n),
      .blankIn_n   (blankIn_n[k]),
      .rippleIn_n  (rippleIn_n[k]),
      .segN        (segN[SEG_W*k +: SEG_W]),
      .rippleOut_n (rippleOut_n[k])
    );

    if (k < MSD) begin : g_chk
      always_comb begin
        if (rippleOut_n[k+1] && bcdIn[BCD_W*k +: BCD_W] == '0 && blankIn_n[k] && lampTest_n)
          AST_EMBEDDED_ZERO_LIT: assert (segN[SEG_W*k +: SEG_W] == 7'h40); // R7
      end
    end
  end

endmodule

// File: tb/sevenseg_chain_tb_top.sv
`timescale 1ns/1ps
module sevenseg_chain_tb_top;

  localparam int ND = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [4*ND-1:0] bcdIn;
  logic [ND-1:0]   blankIn_n;
  logic            lampTest_n;
  logic            leadBlank_n;
  logic [7*ND-1:0] segN;
  logic [ND-1:0]   rippleOut_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  sevenseg_chain #(.DIGITS(ND), .KEEP_LAST_ZERO(1'b1)) dut_i (
    .bcdIn       (bcdIn),
    .blankIn_n   (blankIn_n),
    .lampTest_n  (lampTest_n),
    .leadBlank_n (leadBlank_n),
    .segN        (segN),
    .rippleOut_n (rippleOut_n)
  );

  function automatic logic [6:0] refGlyph(input int v);
    case (v)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h40;
    endcase
  endfunction

  task automatic compareAll(input string ctx);
    logic rip;
    rip = leadBlank_n;
    for (int k = ND - 1; k >= 0; k--) begin
      int v;
      logic rin, rout;
      logic [6:0] expSeg, gotSeg;
      string tag;
      v   = int'(bcdIn[4*k +: 4]);
      rin = (k == 0) ? 1'b1 : rip;            // R8: last digit kept
      rout = !((v == 0) && !rin);             // R6
      if (!blankIn_n[k]) begin expSeg = 7'h7F; tag = "R4"; end
      else if (!lampTest_n) begin expSeg = 7'h00; tag = "R3"; end
      else if (!rout) begin expSeg = 7'h7F; tag = "R5/R7"; end
      else begin
        expSeg = ~refGlyph(v);
        tag = (v > 9) ? "R2" : ((v == 0 && k == 0) ? "R8" : (leadBlank_n ? "R9" : "R1"));
      end
      gotSeg = segN[7*k +: 7];
      checks++;
      if (gotSeg !== expSeg) begin
        fails++;
        $display("FAIL %s %s digit %0d segN got %h expected %h", tag, ctx, k, gotSeg, expSeg);
      end
      checks++;
      if (rippleOut_n[k] !== rout) begin
        fails++;
        $display("FAIL R6 %s digit %0d rippleOut_n got %b expected %b", ctx, k, rippleOut_n[k], rout);
      end
      rip = rout;
    end
  endtask

  task automatic apply(input logic [4*ND-1:0] b, input logic [ND-1:0] bi,
                       input logic lt, input logic lead, input string ctx);
    @(posedge clk);
    bcdIn = b; blankIn_n = bi; lampTest_n = lt; leadBlank_n = lead;
    @(negedge clk);
    compareAll(ctx);
  endtask

  initial begin
    bcdIn = '0; blankIn_n = '1; lampTest_n = 1'b1; leadBlank_n = 1'b0;
    // initial state: all zeros, suppression on -> dark, dark, 0 (R8)
    apply(12'h000, 3'b111, 1'b1, 1'b0, "initial R8");
    apply(12'h012, 3'b111, 1'b1, 1'b0, "leading R7");
    apply(12'h203, 3'b111, 1'b1, 1'b0, "embedded R7");
    apply(12'h100, 3'b111, 1'b1, 1'b0, "trailing R7");
    apply(12'h005, 3'b111, 1'b1, 1'b1, "no-lead R9");
    apply(12'h0A0, 3'b111, 1'b1, 1'b0, "badcode R2");
    apply(12'h000, 3'b111, 1'b0, 1'b0, "lamp R3");
    apply(12'h888, 3'b010, 1'b0, 1'b0, "blank over lamp R4");
    for (int v = 0; v < 16384; v++) begin
      logic [1:0] mode;
      logic [ND-1:0] bi;
      mode = v[13:12];
      bi = (mode == 2'b10) ? ~(3'b001 << (v % 3)) : 3'b111;
      apply(v[11:0], bi, (mode != 2'b11), v[12], "sweep R1");
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule